// File: doc/BRIEF.md
# Dual-Port Control Register Bank

This block holds a small set of 64-bit control and status words that two agents reach through separate ports. The configuration port addresses the bank by word index directly. The memory-mapped port uses its own word index, and the bank adds a fixed offset to that index. Its window therefore begins at the base-address word, and the words below that index cannot be reached from it. Every access moves one whole 64-bit word. A byte address maps to a word index by shifting it right by three; that shift happens outside the block.

Besides plain storage, the bank has alias indices that modify a word in place. One pair sets or clears bits in the control word. Another pair ANDs or ORs bits into the fault word. The base-address word decodes the block's window and carries an enable flag. Only the configuration port may change it. Interrupt routing words are not stored here: a write to one of them leaves the block on a strobe with its index and data. An error pulse marks writes that are refused and accesses to indices that do not exist. The current base address, its enable flag and the control word are driven as outputs.

Top module: `dpcsr_bank`

## Requirements
- R1: A configuration access at index i targets word i. A memory-mapped access at index n targets word n+10. A translated index above 27 behaves as an unimplemented index.
- R2: When both ports request in the same cycle, only the configuration access takes effect. `mm_gnt` is high exactly when `mm_req` is high and `cfg_req` is low.
- R3: Word 0 is the fault word and reads back what was written. A write to index 1 ANDs the data into it. A write to index 2 ORs the data into it.
- R4: Word 14 is the control word and `ctrl_o` always shows it. A write to index 18 sets the written bits. A write to index 19 clears the written bits.
- R5: A configuration write to word 10 keeps only the bits under mask 0x0003fffffff00000, plus bit 0. `base_addr_o` is word 10 under that mask, and `base_en_o` is its bit 0.
- R6: A memory-mapped write to word 10 leaves the word unchanged and raises `err_o`.
- R7: Word 11 keeps only the bits under mask 0x0003ffff00000000.
- R8: Word 21 reads the `stat_i` input. A write to it changes nothing and raises `err_o`.
- R9: A read of any index not named in R3, R4, R5, R7, R8, R10 or R11 returns all ones and raises `err_o`. A write to such an index changes nothing and raises `err_o`. A read of an alias index (1, 2, 18, 19) returns all ones without an error.
- R10: Words 6, 7, 15 and 20 are plain read/write storage.
- R11: A write to a routing index (16, or 22 to 27) pulses `rt_stb_o` one cycle later, with `rt_idx_o` set to the target word index and `rt_data_o` set to the written data. A read of a routing index returns all ones without an error.
- R12: After reset, every word reads zero except word 10. Word 10 holds `BAR_RESET` under the R5 mask, with bit 0 set. `err_o` and `rt_stb_o` are low.
- R13: `err_o` is high in the cycle after an accepted offending access and low after any legal access or idle cycle. Read data on either port is valid in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration port access request |
| cfg_we | input | 1 | Configuration port write (1) or read (0) |
| cfg_idx | input | IDX_W | Configuration port word index |
| cfg_wdata | input | 64 | Configuration port write data |
| cfg_rdata | output | 64 | Configuration port read data, same cycle |
| mm_req | input | 1 | Memory-mapped port access request |
| mm_we | input | 1 | Memory-mapped port write (1) or read (0) |
| mm_idx | input | MM_IDX_W | Memory-mapped word index before the offset is added |
| mm_wdata | input | 64 | Memory-mapped port write data |
| mm_rdata | output | 64 | Memory-mapped port read data, valid while granted |
| mm_gnt | output | 1 | Memory-mapped access accepted this cycle |
| stat_i | input | 64 | Live interrupt status, read at word 21 |
| base_addr_o | output | 64 | Masked base address from word 10 |
| base_en_o | output | 1 | Base decode enable (word 10 bit 0) |
| ctrl_o | output | 64 | Control word 14 |
| err_o | output | 1 | One-cycle error pulse |
| rt_stb_o | output | 1 | Routing write strobe |
| rt_idx_o | output | IDX_W | Word index of the routing write |
| rt_data_o | output | 64 | Data of the routing write |

## Verification
The bench builds the block with 5-bit indices on both ports and the default offset of 10. With those values, memory-mapped indices 18 to 31 translate past the last word and land on the unimplemented path. The bench also sets `BAR_RESET` to a value with bits outside the base mask, so the reset check shows that the mask applies to the reset load as well as to writes. A behavioural model tracks every word and the expected strobes. It compares outputs on every clock, including the cycles where both ports collide and the memory-mapped write must leave no trace.

// File: rtl/dpcsr_pkg.sv
package dpcsr_pkg;

   localparam int unsigned DW      = 64;
   localparam int unsigned N_PLAIN = 4;
   localparam int unsigned PSEL_W  = $clog2(N_PLAIN);

   // word indices whose position matters to the offset mapping and aliases
   localparam int IX_FAULT = 0;
   localparam int IX_FAND  = 1;
   localparam int IX_FOR   = 2;
   localparam int IX_SP0   = 6;
   localparam int IX_SP1   = 7;
   localparam int IX_BAR   = 10;
   localparam int IX_SBAR  = 11;
   localparam int IX_CTRL  = 14;
   localparam int IX_SP2   = 15;
   localparam int IX_RT0   = 16;
   localparam int IX_CSET  = 18;
   localparam int IX_CCLR  = 19;
   localparam int IX_SP3   = 20;
   localparam int IX_STAT  = 21;
   localparam int IX_RT1   = 22;
   localparam int IX_RTN   = 27;

   typedef enum logic [3:0] {
      K_NONE,
      K_FAULT,
      K_FAULT_AND,
      K_FAULT_OR,
      K_PLAIN,
      K_BAR,
      K_SBAR,
      K_CTRL,
      K_CTRL_SET,
      K_CTRL_CLR,
      K_STAT,
      K_ROUTE
   } slot_kind_e;

endpackage

// File: rtl/dpcsr_decode.sv
module dpcsr_decode
   import dpcsr_pkg::*;
#(
   parameter int unsigned AW = 6
)(
   input  logic [AW-1:0]     idx,
   output slot_kind_e        kind,
   output logic [PSEL_W-1:0] psel
);

   always_comb begin
      kind = K_NONE;
      psel = '0;
      if      (idx == AW'(IX_FAULT)) kind = K_FAULT;
      else if (idx == AW'(IX_FAND))  kind = K_FAULT_AND;
      else if (idx == AW'(IX_FOR))   kind = K_FAULT_OR;
      else if (idx == AW'(IX_SP0)) begin kind = K_PLAIN; psel = PSEL_W'(0); end
      else if (idx == AW'(IX_SP1)) begin kind = K_PLAIN; psel = PSEL_W'(1); end
      else if (idx == AW'(IX_SP2)) begin kind = K_PLAIN; psel = PSEL_W'(2); end
      else if (idx == AW'(IX_SP3)) begin kind = K_PLAIN; psel = PSEL_W'(3); end
      else if (idx == AW'(IX_BAR))   kind = K_BAR;
      else if (idx == AW'(IX_SBAR))  kind = K_SBAR;
      else if (idx == AW'(IX_CTRL))  kind = K_CTRL;
      else if (idx == AW'(IX_CSET))  kind = K_CTRL_SET;
      else if (idx == AW'(IX_CCLR))  kind = K_CTRL_CLR;
      else if (idx == AW'(IX_STAT))  kind = K_STAT;
      else if (idx == AW'(IX_RT0))   kind = K_ROUTE;
      else if (idx >= AW'(IX_RT1) && idx <= AW'(IX_RTN)) kind = K_ROUTE;
   end

endmodule

// File: rtl/dpcsr_arb.sv
module dpcsr_arb
   import dpcsr_pkg::*;
#(
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned MM_IDX_W  = 5,
   parameter int unsigned MM_OFFSET = 10,
   parameter int unsigned AW        = 6
)(
   input  logic                cfg_req,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [DW-1:0]       cfg_wdata,
   input  logic                mm_req,
   input  logic                mm_we,
   input  logic [MM_IDX_W-1:0] mm_idx,
   input  logic [DW-1:0]       mm_wdata,
   output logic                mm_gnt,
   output logic [AW-1:0]       cfg_xidx,
   output logic [AW-1:0]       mm_xidx,
   output logic                acc_vld,
   output logic                acc_we,
   output logic                acc_mm,
   output logic [IDX_W-1:0]    acc_idx,
   output logic [DW-1:0]       acc_data
);

   // both ports land in one index space; the memory-mapped one is shifted
   assign cfg_xidx = AW'(cfg_idx);
   assign mm_xidx  = AW'(mm_idx) + AW'(MM_OFFSET);

   // fixed priority: configuration port wins a collision
   assign mm_gnt   = mm_req & ~cfg_req;
   assign acc_vld  = cfg_req | mm_req;
   assign acc_mm   = ~cfg_req;
   assign acc_we   = cfg_req ? cfg_we    : mm_we;
   assign acc_data = cfg_req ? cfg_wdata : mm_wdata;
   assign acc_idx  = cfg_req ? cfg_idx   : mm_xidx[IDX_W-1:0];

endmodule

// File: rtl/dpcsr_rdmux.sv
module dpcsr_rdmux
   import dpcsr_pkg::*;
#(
   parameter int unsigned AW = 6
)(
   input  logic [AW-1:0]     idx,
   input  logic [DW-1:0]     fault_q,
   input  logic [DW-1:0]     bar_q,
   input  logic [DW-1:0]     sbar_q,
   input  logic [DW-1:0]     ctrl_q,
   input  logic [DW-1:0]     plain_q [N_PLAIN],
   input  logic [DW-1:0]     stat_i,
   output logic [DW-1:0]     rdata,
   output slot_kind_e        kind,
   output logic [PSEL_W-1:0] psel
);

   dpcsr_decode #(.AW(AW)) u_dec (
      .idx  (idx),
      .kind (kind),
      .psel (psel)
   );

   always_comb begin
      case (kind)
         K_FAULT: rdata = fault_q;
         K_PLAIN: rdata = plain_q[psel];
         K_BAR:   rdata = bar_q;
         K_SBAR:  rdata = sbar_q;
         K_CTRL:  rdata = ctrl_q;
         K_STAT:  rdata = stat_i;
         default: rdata = '1;
      endcase
   end

endmodule

// File: rtl/dpcsr_regs.sv
module dpcsr_regs
   import dpcsr_pkg::*;
#(
   parameter logic [63:0] BAR_MASK  = 64'h0003_ffff_fff0_0000,
   parameter logic [63:0] SBAR_MASK = 64'h0003_ffff_0000_0000,
   parameter logic [63:0] BAR_RESET = 64'h0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  slot_kind_e        wr_kind,
   input  logic [PSEL_W-1:0] wr_psel,
   input  logic              wr_mm,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     fault_q,
   output logic [DW-1:0]     bar_q,
   output logic [DW-1:0]     sbar_q,
   output logic [DW-1:0]     ctrl_q,
   output logic [DW-1:0]     plain_q [N_PLAIN]
);

   localparam logic [DW-1:0] BAR_KEEP = BAR_MASK | DW'(1);
   localparam logic [DW-1:0] BAR_INIT = (BAR_RESET & BAR_MASK) | DW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= '0;
      end else if (wr_en) begin
         if      (wr_kind == K_FAULT)     fault_q <= wr_data;
         else if (wr_kind == K_FAULT_AND) fault_q <= fault_q & wr_data;
         else if (wr_kind == K_FAULT_OR)  fault_q <= fault_q | wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         if      (wr_kind == K_CTRL)     ctrl_q <= wr_data;
         else if (wr_kind == K_CTRL_SET) ctrl_q <= ctrl_q | wr_data;
         else if (wr_kind == K_CTRL_CLR) ctrl_q <= ctrl_q & ~wr_data;
      end
   end

   // base word: refused from the memory-mapped side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 bar_q <= BAR_INIT;
      else if (wr_en && wr_kind == K_BAR && !wr_mm) bar_q <= wr_data & BAR_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sbar_q <= '0;
      else if (wr_en && wr_kind == K_SBAR) sbar_q <= wr_data & SBAR_MASK;
   end

   for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            plain_q[g] <= '0;
         else if (wr_en && wr_kind == K_PLAIN && wr_psel == PSEL_W'(g))
            plain_q[g] <= wr_data;
      end
   end

endmodule

// File: rtl/dpcsr_bank.sv
module dpcsr_bank
   import dpcsr_pkg::*;
#(
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned MM_IDX_W  = 5,
   parameter int unsigned MM_OFFSET = 10,
   parameter logic [63:0] BAR_MASK  = 64'h0003_ffff_fff0_0000,
   parameter logic [63:0] SBAR_MASK = 64'h0003_ffff_0000_0000,
   parameter logic [63:0] BAR_RESET = 64'h0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_req,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [DW-1:0]       cfg_wdata,
   output logic [DW-1:0]       cfg_rdata,
   input  logic                mm_req,
   input  logic                mm_we,
   input  logic [MM_IDX_W-1:0] mm_idx,
   input  logic [DW-1:0]       mm_wdata,
   output logic [DW-1:0]       mm_rdata,
   output logic                mm_gnt,
   input  logic [DW-1:0]       stat_i,
   output logic [DW-1:0]       base_addr_o,
   output logic                base_en_o,
   output logic [DW-1:0]       ctrl_o,
   output logic                err_o,
   output logic                rt_stb_o,
   output logic [IDX_W-1:0]    rt_idx_o,
   output logic [DW-1:0]       rt_data_o
);

   localparam int unsigned AW = ((IDX_W > MM_IDX_W) ? IDX_W : MM_IDX_W) + 1;

   // elaboration-time parameter checks
   if (IDX_W < 5) begin : g_chk_idx
      $error("IDX_W must cover word index 27");
   end
   if (MM_OFFSET >= (1 << IDX_W)) begin : g_chk_off
      $error("MM_OFFSET must lie inside the configuration index space");
   end
   if (BAR_MASK[0]) begin : g_chk_mask
      $error("BAR_MASK must leave bit 0 for the enable flag");
   end

   logic [AW-1:0]     cfg_xidx, mm_xidx;
   logic              acc_vld, acc_we, acc_mm;
   logic [IDX_W-1:0]  acc_idx;
   logic [DW-1:0]     acc_data;
   slot_kind_e        cfg_kind, mm_kind, acc_kind;
   logic [PSEL_W-1:0] cfg_psel, mm_psel, acc_psel;
   logic [DW-1:0]     fault_q, bar_q, sbar_q, ctrl_q;
   logic [DW-1:0]     plain_q [N_PLAIN];
   logic              bad, fwd;

   dpcsr_arb #(
      .IDX_W(IDX_W), .MM_IDX_W(MM_IDX_W), .MM_OFFSET(MM_OFFSET), .AW(AW)
   ) u_arb (
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .mm_req(mm_req), .mm_we(mm_we), .mm_idx(mm_idx), .mm_wdata(mm_wdata),
      .mm_gnt(mm_gnt), .cfg_xidx(cfg_xidx), .mm_xidx(mm_xidx),
      .acc_vld(acc_vld), .acc_we(acc_we), .acc_mm(acc_mm),
      .acc_idx(acc_idx), .acc_data(acc_data)
   );

   dpcsr_rdmux #(.AW(AW)) u_rd_cfg (
      .idx(cfg_xidx), .fault_q(fault_q), .bar_q(bar_q), .sbar_q(sbar_q),
      .ctrl_q(ctrl_q), .plain_q(plain_q), .stat_i(stat_i),
      .rdata(cfg_rdata), .kind(cfg_kind), .psel(cfg_psel)
   );

   dpcsr_rdmux #(.AW(AW)) u_rd_mm (
      .idx(mm_xidx), .fault_q(fault_q), .bar_q(bar_q), .sbar_q(sbar_q),
      .ctrl_q(ctrl_q), .plain_q(plain_q), .stat_i(stat_i),
      .rdata(mm_rdata), .kind(mm_kind), .psel(mm_psel)
   );

   // the read-side decode of the winning port also steers the write
   assign acc_kind = cfg_req ? cfg_kind : mm_kind;
   assign acc_psel = cfg_req ? cfg_psel : mm_psel;

   dpcsr_regs #(
      .BAR_MASK(BAR_MASK), .SBAR_MASK(SBAR_MASK), .BAR_RESET(BAR_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(acc_vld & acc_we), .wr_kind(acc_kind), .wr_psel(acc_psel),
      .wr_mm(acc_mm), .wr_data(acc_data),
      .fault_q(fault_q), .bar_q(bar_q), .sbar_q(sbar_q), .ctrl_q(ctrl_q),
      .plain_q(plain_q)
   );

   assign bad = acc_vld && ((acc_kind == K_NONE)
                         || (acc_we && acc_kind == K_STAT)
                         || (acc_we && acc_mm && acc_kind == K_BAR));
   assign fwd = acc_vld && acc_we && (acc_kind == K_ROUTE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_o     <= 1'b0;
         rt_stb_o  <= 1'b0;
         rt_idx_o  <= '0;
         rt_data_o <= '0;
      end else begin
         err_o    <= bad;
         rt_stb_o <= fwd;
         if (fwd) begin
            rt_idx_o  <= acc_idx;
            rt_data_o <= acc_data;
         end
      end
   end

   assign base_addr_o = bar_q & BAR_MASK;
   assign base_en_o   = bar_q[0];
   assign ctrl_o      = ctrl_q;

   assert_ctrl_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_we && cfg_idx == IDX_W'(IX_CSET))
      |=> ctrl_o == ($past(ctrl_o) | $past(cfg_wdata)));

   assert_ctrl_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_we && cfg_idx == IDX_W'(IX_CCLR))
      |=> ctrl_o == ($past(ctrl_o) & ~$past(cfg_wdata)));

   assert_mm_base_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_gnt && mm_we && mm_xidx == AW'(IX_BAR))
      |=> ($stable(base_addr_o) && $stable(base_en_o) && err_o));

   assert_stat_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_we && cfg_idx == IDX_W'(IX_STAT)) |=> err_o);

   assert_route_fwd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_we && cfg_idx == IDX_W'(IX_RT0))
      |=> (rt_stb_o && rt_idx_o == $past(cfg_idx) && rt_data_o == $past(cfg_wdata)));

   assert_collide_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_we && mm_req && mm_we) |=> $stable(ctrl_o) && $stable(base_addr_o));

endmodule

// File: tb/test_dpcsr_bank.sv
`timescale 1ns/1ps
module test_dpcsr_bank;

   localparam logic [63:0] BMASK = 64'h0003_ffff_fff0_0000;
   localparam logic [63:0] SMASK = 64'h0003_ffff_0000_0000;
   localparam logic [63:0] BRST  = 64'hffff_1234_5678_9abc;
   localparam int          OFS   = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_req = 0, cfg_we = 0, mm_req = 0, mm_we = 0;
   logic [4:0]  cfg_idx = '0, mm_idx = '0;
   logic [63:0] cfg_wdata = '0, mm_wdata = '0, stat_v = 64'h0000_0011_2233_4455;
   logic [63:0] cfg_rdata, mm_rdata, base_addr_o, ctrl_o, rt_data_o;
   logic        mm_gnt, base_en_o, err_o, rt_stb_o;
   logic [4:0]  rt_idx_o;

   always #10 clk = ~clk;

   dpcsr_bank #(
      .IDX_W(5), .MM_IDX_W(5), .MM_OFFSET(OFS), .BAR_RESET(BRST)
   ) i_dpcsr_bank (
      .clk(clk), .rst_n(rst_n),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .mm_req(mm_req), .mm_we(mm_we), .mm_idx(mm_idx), .mm_wdata(mm_wdata),
      .mm_rdata(mm_rdata), .mm_gnt(mm_gnt), .stat_i(stat_v),
      .base_addr_o(base_addr_o), .base_en_o(base_en_o), .ctrl_o(ctrl_o),
      .err_o(err_o), .rt_stb_o(rt_stb_o), .rt_idx_o(rt_idx_o), .rt_data_o(rt_data_o)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   // behavioural model
   logic [63:0] mreg [32];
   bit          exp_err;
   bit          exp_rt;
   int          exp_rt_idx;
   logic [63:0] exp_rt_data;

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic bit is_store(int i);
      return i == 0 || i == 6 || i == 7 || i == 10 || i == 11 || i == 14 || i == 15 || i == 20;
   endfunction
   function automatic bit is_route(int i);
      return i == 16 || (i >= 22 && i <= 27);
   endfunction
   function automatic bit is_known(int i);
      return is_store(i) || is_route(i) || i == 21 || i == 1 || i == 2 || i == 18 || i == 19;
   endfunction
   function automatic logic [63:0] m_read(int i);
      if (is_store(i)) return mreg[i];
      if (i == 21)     return stat_v;
      return '1;
   endfunction

   task automatic m_apply(int i, bit we, bit mm, logic [63:0] d);
      if (!is_known(i)) begin
         exp_err = 1;
         return;
      end
      if (!we) return;
      if (is_route(i)) begin
         exp_rt = 1; exp_rt_idx = i; exp_rt_data = d;
      end else begin
         case (i)
            1:  mreg[0] = mreg[0] & d;
            2:  mreg[0] = mreg[0] | d;
            10: if (mm) exp_err = 1; else mreg[10] = d & (BMASK | 64'h1);
            11: mreg[11] = d & SMASK;
            18: mreg[14] = mreg[14] | d;
            19: mreg[14] = mreg[14] & ~d;
            21: exp_err = 1;
            default: mreg[i] = d;
         endcase
      end
   endtask

   task automatic compare_outs(string tag);
      chk({tag, " R5 base_addr_o"}, base_addr_o, mreg[10] & BMASK);
      chk({tag, " R5 base_en_o"}, 64'(base_en_o), 64'(mreg[10][0]));
      chk({tag, " R4 ctrl_o"}, ctrl_o, mreg[14]);
      chk({tag, " R13 err_o"}, 64'(err_o), 64'(exp_err));
      chk({tag, " R11 rt_stb_o"}, 64'(rt_stb_o), 64'(exp_rt));
      if (exp_rt) begin
         chk({tag, " R11 rt_idx_o"}, 64'(rt_idx_o), 64'(exp_rt_idx));
         chk({tag, " R11 rt_data_o"}, rt_data_o, exp_rt_data);
      end
   endtask

   // one clock: drive, check same-cycle read data, update model, compare
   task automatic cyc(bit cr, bit cw, int ci, logic [63:0] cd,
                      bit mr, bit mw, int mi, logic [63:0] md, string tag);
      cfg_req = cr; cfg_we = cw; cfg_idx = 5'(ci); cfg_wdata = cd;
      mm_req = mr; mm_we = mw; mm_idx = 5'(mi); mm_wdata = md;
      #1;
      chk({tag, " R2 mm_gnt"}, 64'(mm_gnt), 64'(mr && !cr));
      if (cr && !cw) chk({tag, " R1 cfg_rdata"}, cfg_rdata, m_read(ci));
      if (mr && !cr && !mw) chk({tag, " R1 mm_rdata"}, mm_rdata, m_read(mi + OFS));
      @(posedge clk);
      exp_err = 0; exp_rt = 0;
      if (cr)      m_apply(ci, cw, 0, cd);
      else if (mr) m_apply(mi + OFS, mw, 1, md);
      @(negedge clk);
      compare_outs(tag);
   endtask

   task automatic cw_(int i, logic [63:0] d, string tag); cyc(1, 1, i, d, 0, 0, 0, '0, tag); endtask
   task automatic cr_(int i, string tag);                 cyc(1, 0, i, '0, 0, 0, 0, '0, tag); endtask
   task automatic mw_(int i, logic [63:0] d, string tag); cyc(0, 0, 0, '0, 1, 1, i, d, tag); endtask
   task automatic mr_(int i, string tag);                 cyc(0, 0, 0, '0, 1, 0, i, '0, tag); endtask
   task automatic idle(string tag);                       cyc(0, 0, 0, '0, 0, 0, 0, '0, tag); endtask

   initial begin : wd
      repeat (200000) @(posedge clk);
      if (!done) begin
         compared++; mismatched++;
         $display("FAIL watchdog R13: actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < 32; i++) mreg[i] = '0;
      mreg[10] = (BRST & BMASK) | 64'h1;
      exp_err = 0; exp_rt = 0; exp_rt_idx = 0; exp_rt_data = '0;
      repeat (3) @(negedge clk);
      compare_outs("R12 in reset");
      rst_n = 1'b1;
      idle("R12 idle");
      cr_(0, "R12 fault"); cr_(10, "R12 base"); cr_(14, "R12 ctrl");
      cr_(11, "R12 sbase"); cr_(6, "R12 plain");

      // R3 fault word and its aliases
      cw_(0, 64'ha5a5_a5a5_5a5a_5a5a, "R3 write");
      cr_(0, "R3 read");
      cw_(1, 64'h0f0f_0f0f_ffff_0000, "R3 and");
      cr_(0, "R3 after and");
      cw_(2, 64'h8000_0000_0000_0003, "R3 or");
      cr_(0, "R3 after or");
      cr_(1, "R3 alias read");

      // R4 control word
      cw_(14, 64'h1234_0000_0000_00f0, "R4 write");
      cw_(18, 64'h0000_0000_0000_000f, "R4 set");
      cw_(19, 64'h1000_0000_0000_0030, "R4 clear");
      cr_(14, "R4 read"); cr_(18, "R4 alias read");

      // R5 base word
      cw_(10, '1, "R5 all ones");
      cr_(10, "R5 read");
      cw_(10, 64'h0001_0000_0040_0000, "R5 disable");
      cw_(10, 64'h0002_0000_0100_0001, "R5 enable");

      // R6 memory-mapped base write refused
      mw_(0, 64'h0, "R6 mm base write");
      mr_(0, "R6 mm base read");

      // R7 secondary base
      cw_(11, '1, "R7 write");
      cr_(11, "R7 read");
      mr_(1, "R7 mm read");

      // R10 plain storage through both ports
      cw_(6, 64'h0606_0606_0606_0606, "R10 w6");
      cw_(7, 64'h0707_0707_0707_0707, "R10 w7");
      mw_(5, 64'h0f0f_0000_1515_0000, "R10 mm w15");
      mw_(10, 64'h2020_2020_0000_ffff, "R10 mm w20");
      cr_(6, "R10 r6"); cr_(7, "R10 r7"); cr_(15, "R10 r15"); mr_(10, "R10 mm r20");

      // R8 status word
      cr_(21, "R8 read");
      cw_(21, '0, "R8 write");
      stat_v = 64'hdead_0000_beef_0001;
      cr_(21, "R8 reread");

      // R9 unimplemented indices
      for (int i = 3; i < 32; i++)
         if (!is_known(i)) cr_(i, "R9 read");
      cw_(3, 64'h3, "R9 write");
      cw_(28, 64'h1c, "R9 write high");
      mr_(18, "R9 mm overflow read");
      mw_(31, '1, "R9 mm overflow write");

      // R11 routing forwards
      cw_(16, 64'h1616_1616_0000_0001, "R11 w16");
      cw_(22, 64'h2222_0000_0000_0002, "R11 w22");
      cw_(27, 64'h2727_0000_0000_0003, "R11 w27");
      mw_(6, 64'h0000_1616_0000_0004, "R11 mm w16");
      mw_(17, 64'h0000_2727_0000_0005, "R11 mm w27");
      cr_(16, "R11 read"); cr_(25, "R11 read");

      // R2 collisions
      cyc(1, 0, 14, '0, 1, 1, 4, 64'hffff_ffff_ffff_ffff, "R2 read vs mm ctrl write");
      cyc(1, 1, 6, 64'h6666, 1, 1, 10, 64'h7777, "R2 both write");
      cr_(20, "R2 mm lost"); cr_(6, "R2 cfg won");
      cyc(1, 1, 3, '0, 1, 0, 4, '0, "R2 cfg error wins");

      // R1 memory-mapped mapping
      mr_(4, "R1 mm ctrl read");
      mw_(8, 64'h0000_0000_ff00_0000, "R1 mm set");
      mw_(9, 64'h0000_0000_0f00_0000, "R1 mm clear");
      mw_(4, 64'h0bad_cafe_0000_0000, "R1 mm ctrl write");
      cr_(14, "R1 ctrl readback");

      // R13 error timing
      cr_(4, "R13 err a"); cr_(5, "R13 err b"); cr_(0, "R13 legal");
      idle("R13 idle"); idle("R13 idle2");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule